// File: doc/BRIEF.md
# Indexed interrupt configuration unit

This block is an interrupt unit that software programs over a small auxiliary-register bus. Vector numbers 0 to 15 belong to exceptions and cannot be configured here. Vectors 16 and above map to external interrupt lines, so line `k` is vector `16 + k`. Each line has its own priority, trigger mode, enable bit and pending state. Software does not address these per-line fields directly. It first writes a vector number into a shared select register. Later accesses to the priority, trigger, enable and cancel registers then act on that one line only.

The unit samples the incoming lines every cycle. A level-mode line is pending for as long as its input is high. A pulse-mode line latches on a rising edge and stays pending until software writes 1 to the cancel register, normally at end of interrupt. The unit ignores lines that are not enabled. Among the remaining lines it picks the one with the smallest priority value, and on a tie the lower vector wins. It shows that vector with a valid flag. It raises a request only when the winner is more urgent than the threshold the CPU supplies. A control register and a vector-base register are plain 32-bit storage, so software can save and restore them around a power-down.

Top module: `irq_cfg_unit`

## Requirements
- R1: After reset the select register reads 16. Every line reads priority 15 (2^PRIO_W-1), secure bit 0, trigger 0 and enable 0. The control and vector-base registers read 0, and `vec_valid_o` and `req_o` are 0.
- R2: The select register is at address 0 and reads back its value in the low bits. A write of a value below 16, or of a value not below NUM_VEC, is ignored and the previous selection stays.
- R3: The priority register (address 1), trigger register (address 2, bit 0) and enable register (address 3, bit 0) access only the line whose vector is held in the select register. Writing them changes no other line.
- R4: With trigger bit 0 (level mode), a line is pending exactly while its input is high. The pending state of the selected line reads at address 4, bit 0.
- R5: With trigger bit 1 (pulse mode), a rising edge of the input latches the pending state, and it stays set after the input falls. Only a write to address 4 with bit 0 set clears it. A write there with bit 0 clear has no effect.
- R6: A line whose enable bit is 0 never wins, even while it is pending.
- R7: Among pending enabled lines, the one with the numerically smallest priority wins. On equal priority the lower vector number wins.
- R8: `req_o` is 1 only when a winner exists and its priority is numerically less than `thresh_i`.
- R9: With SECURE set, bit PRIO_W (bit 4 by default) of the priority register is a secure attribute. It is stored and read back together with the priority field in bits 3:0.
- R10: The control register (address 5) and vector-base register (address 6) read back all 32 written bits. A write to an unmapped address changes neither of them.
- R11: `vec_o`, `vec_valid_o` and `req_o` are registered. They reflect the pending, enable, priority and threshold state of the previous cycle, one clock after a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aux_wr_i | input | 1 | Register write strobe |
| aux_addr_i | input | 4 | Register address |
| aux_wdata_i | input | 32 | Write data |
| aux_rdata_o | output | 32 | Read data for `aux_addr_i`, combinational |
| irq_i | input | NUM_VEC-16 | Interrupt lines, bit k is vector 16+k |
| thresh_i | input | PRIO_W+1 | Current CPU priority threshold |
| vec_o | output | $clog2(NUM_VEC) | Winning vector number |
| vec_valid_o | output | 1 | A pending enabled line exists |
| req_o | output | 1 | Winner is more urgent than the threshold |

## Verification
The assertions assume that the select register always holds a line vector, so the per-line decode never sees an index past the last line. The bench keeps to this by only using vectors 16 to 63 for per-line accesses, and it tries out-of-range selections only to confirm they are ignored. The cancel check assumes that a rising edge arriving in the same cycle as a cancel write takes priority. The bench therefore never pulses a line in the cycle it cancels it. The bench holds inputs stable across each sampling point: it drives everything on the falling edge and changes the threshold only while no register write is in progress.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
  localparam int unsigned EXC_VECS = 16;
  localparam int unsigned AUX_AW   = 4;
  localparam int unsigned AUX_DW   = 32;

  typedef enum logic [AUX_AW-1:0] {
    A_SEL    = 4'd0,
    A_PRIO   = 4'd1,
    A_TRIG   = 4'd2,
    A_EN     = 4'd3,
    A_CANCEL = 4'd4,
    A_CTRL   = 4'd5,
    A_VBASE  = 4'd6
  } aux_addr_e;
endpackage

// File: rtl/irq_aux_regs.sv
module irq_aux_regs
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NUM_VEC = 64,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AUX_AW-1:0] addr_i,
  input  logic [AUX_DW-1:0] wdata_i,
  output logic [VEC_W-1:0]  sel_o,
  output logic [AUX_DW-1:0] ctrl_o,
  output logic [AUX_DW-1:0] vbase_o,
  output logic              prio_we_o,
  output logic              trig_we_o,
  output logic              en_we_o,
  output logic              cancel_we_o
);
  logic [VEC_W-1:0] sel_q;
  logic             sel_ok;

  // only line vectors may be selected
  assign sel_ok = (wdata_i >= AUX_DW'(EXC_VECS)) && (wdata_i < AUX_DW'(NUM_VEC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= VEC_W'(EXC_VECS);
      ctrl_o  <= '0;
      vbase_o <= '0;
    end else if (wr_i) begin
      if (addr_i == A_SEL && sel_ok) sel_q <= wdata_i[VEC_W-1:0];
      if (addr_i == A_CTRL)          ctrl_o  <= wdata_i;
      if (addr_i == A_VBASE)         vbase_o <= wdata_i;
    end
  end

  assign sel_o       = sel_q;
  assign prio_we_o   = wr_i && (addr_i == A_PRIO);
  assign trig_we_o   = wr_i && (addr_i == A_TRIG);
  assign en_we_o     = wr_i && (addr_i == A_EN);
  assign cancel_we_o = wr_i && (addr_i == A_CANCEL);

  // R2
  sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q >= VEC_W'(EXC_VECS)) && (32'(sel_q) < NUM_VEC));

  // R10
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == A_CTRL)) |=> $stable(ctrl_o));

  // R10
  vbase_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == A_VBASE)) |=> (vbase_o == $past(wdata_i)));
endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
  parameter int unsigned NUM_LINES = 48,
  parameter int unsigned PRIO_W    = 4,
  parameter bit          SECURE    = 1'b1,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam logic [PRIO_W-1:0] PRIO_MAX = {PRIO_W{1'b1}}
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_LINES-1:0]             irq_i,
  input  logic [LINE_W-1:0]                sel_line_i,
  input  logic                             prio_we_i,
  input  logic                             trig_we_i,
  input  logic                             en_we_i,
  input  logic                             cancel_we_i,
  input  logic [PRIO_W:0]                  wdata_i,
  output logic [NUM_LINES-1:0]             pend_o,
  output logic [NUM_LINES-1:0]             en_o,
  output logic [NUM_LINES-1:0][PRIO_W-1:0] prio_o,
  output logic [PRIO_W-1:0]                rd_prio_o,
  output logic                             rd_sec_o,
  output logic                             rd_trig_o,
  output logic                             rd_en_o,
  output logic                             rd_pend_o
);
  logic [NUM_LINES-1:0] trig_q, en_q, irq_q, sticky_q, sec_q;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic hit, edge_seen, cancel;
    assign hit       = (sel_line_i == LINE_W'(k));
    assign edge_seen = irq_i[k] && !irq_q[k];
    assign cancel    = cancel_we_i && wdata_i[0] && hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_q[k]   <= PRIO_MAX;
        trig_q[k]   <= 1'b0;
        en_q[k]     <= 1'b0;
        irq_q[k]    <= 1'b0;
        sticky_q[k] <= 1'b0;
      end else begin
        irq_q[k] <= irq_i[k];
        if (prio_we_i && hit) prio_q[k] <= wdata_i[PRIO_W-1:0];
        if (trig_we_i && hit) trig_q[k] <= wdata_i[0];
        if (en_we_i && hit)   en_q[k]   <= wdata_i[0];
        // a fresh edge wins over a simultaneous cancel
        if (!trig_q[k])     sticky_q[k] <= 1'b0;
        else if (edge_seen) sticky_q[k] <= 1'b1;
        else if (cancel)    sticky_q[k] <= 1'b0;
      end
    end

    if (SECURE) begin : g_sec
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               sec_q[k] <= 1'b0;
        else if (prio_we_i && hit) sec_q[k] <= wdata_i[PRIO_W];
      end
    end else begin : g_nosec
      assign sec_q[k] = 1'b0;
    end

    assign pend_o[k] = trig_q[k] ? sticky_q[k] : irq_i[k];

    // R5
    pulse_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cancel && !edge_seen) |=> !sticky_q[k]);

    // R5
    pulse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sticky_q[k] && trig_q[k] && !cancel && !(trig_we_i && hit)) |=> sticky_q[k]);
  end

  assign en_o      = en_q;
  assign prio_o    = prio_q;
  assign rd_prio_o = prio_q[sel_line_i];
  assign rd_sec_o  = sec_q[sel_line_i];
  assign rd_trig_o = trig_q[sel_line_i];
  assign rd_en_o   = en_q[sel_line_i];
  assign rd_pend_o = pend_o[sel_line_i];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_LINES = 48,
  parameter int unsigned PRIO_W    = 4,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_LINES-1:0]             pend_i,
  input  logic [NUM_LINES-1:0]             en_i,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_i,
  output logic                             win_valid_o,
  output logic [LINE_W-1:0]                win_idx_o,
  output logic [PRIO_W-1:0]                win_prio_o
);
  // strict compare: on a tie the lower index keeps the win
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_prio_o  = '1;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (pend_i[k] && en_i[k] && (!win_valid_o || prio_i[k] < win_prio_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = LINE_W'(k);
        win_prio_o  = prio_i[k];
      end
    end
  end

  // R6
  win_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (en_i[win_idx_o] && pend_i[win_idx_o]));

  // R7
  win_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & en_i) != '0) |-> win_valid_o);
endmodule

// File: rtl/irq_cfg_unit.sv
module irq_cfg_unit
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NUM_VEC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter bit          SECURE  = 1'b1,
  localparam int unsigned NUM_LINES = NUM_VEC - EXC_VECS,
  localparam int unsigned VEC_W     = $clog2(NUM_VEC),
  localparam int unsigned LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 aux_wr_i,
  input  logic [AUX_AW-1:0]    aux_addr_i,
  input  logic [AUX_DW-1:0]    aux_wdata_i,
  output logic [AUX_DW-1:0]    aux_rdata_o,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [PRIO_W:0]      thresh_i,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o,
  output logic                 req_o
);
  logic [VEC_W-1:0]  sel;
  logic [LINE_W-1:0] sel_line;
  logic [AUX_DW-1:0] ctrl_q, vbase_q;
  logic prio_we, trig_we, en_we, cancel_we;
  logic [NUM_LINES-1:0] pend, en;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
  logic [PRIO_W-1:0] rd_prio, win_prio;
  logic rd_sec, rd_trig, rd_en, rd_pend, win_valid;
  logic [LINE_W-1:0] win_idx;

  irq_aux_regs #(.NUM_VEC(NUM_VEC)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(aux_wr_i), .addr_i(aux_addr_i), .wdata_i(aux_wdata_i),
    .sel_o(sel), .ctrl_o(ctrl_q), .vbase_o(vbase_q),
    .prio_we_o(prio_we), .trig_we_o(trig_we), .en_we_o(en_we),
    .cancel_we_o(cancel_we)
  );

  assign sel_line = LINE_W'(sel - VEC_W'(EXC_VECS));

  irq_line_bank #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .SECURE(SECURE)) u_bank (
    .clk_i, .rst_ni, .irq_i,
    .sel_line_i(sel_line),
    .prio_we_i(prio_we), .trig_we_i(trig_we), .en_we_i(en_we),
    .cancel_we_i(cancel_we),
    .wdata_i(aux_wdata_i[PRIO_W:0]),
    .pend_o(pend), .en_o(en), .prio_o(prio),
    .rd_prio_o(rd_prio), .rd_sec_o(rd_sec), .rd_trig_o(rd_trig),
    .rd_en_o(rd_en), .rd_pend_o(rd_pend)
  );

  irq_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_arb (
    .clk_i, .rst_ni,
    .pend_i(pend), .en_i(en), .prio_i(prio),
    .win_valid_o(win_valid), .win_idx_o(win_idx), .win_prio_o(win_prio)
  );

  always_comb begin
    aux_rdata_o = '0;
    case (aux_addr_i)
      A_SEL:    aux_rdata_o = AUX_DW'(sel);
      A_PRIO:   aux_rdata_o = AUX_DW'({rd_sec, rd_prio});
      A_TRIG:   aux_rdata_o = AUX_DW'(rd_trig);
      A_EN:     aux_rdata_o = AUX_DW'(rd_en);
      A_CANCEL: aux_rdata_o = AUX_DW'(rd_pend);
      A_CTRL:   aux_rdata_o = ctrl_q;
      A_VBASE:  aux_rdata_o = vbase_q;
      default:  aux_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
      req_o       <= 1'b0;
    end else begin
      vec_o       <= VEC_W'(EXC_VECS) + VEC_W'(win_idx);
      vec_valid_o <= win_valid;
      req_o       <= win_valid && ({1'b0, win_prio} < thresh_i);
    end
  end

  // R8
  req_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> vec_valid_o);

  // R11
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_o >= VEC_W'(EXC_VECS)) && (32'(vec_o) < NUM_VEC));

  // R11
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |=> vec_valid_o);
endmodule

// File: tb/tb_irq_cfg_unit.sv
module tb_irq_cfg_unit;
  localparam int NUM_VEC = 64;
  localparam int PRIO_W  = 4;
  localparam int NL      = NUM_VEC - 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        aux_wr_i = 1'b0;
  logic [3:0]  aux_addr_i = '0;
  logic [31:0] aux_wdata_i = '0;
  logic [31:0] aux_rdata_o;
  logic [NL-1:0] irq_i = '0;
  logic [PRIO_W:0] thresh_i = 5'd16;
  logic [5:0]  vec_o;
  logic        vec_valid_o, req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_cfg_unit #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .SECURE(1'b1)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    aux_wr_i = 1'b1; aux_addr_i = a; aux_wdata_i = d;
    @(negedge clk_i);
    aux_wr_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    aux_addr_i = a;
    #1;
    check(req, aux_rdata_o, exp);
  endtask

  task automatic cfg(int v, int p, bit trig, bit en);
    wr(0, v); wr(1, p); wr(2, trig); wr(3, en);
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
    #1;
  endtask

  task automatic t_reset;
    #1;
    check("R1 valid", vec_valid_o, 0);
    check("R1 req", req_o, 0);
    rd_chk("R1 sel", 0, 16);
    rd_chk("R1 prio", 1, 15);
    rd_chk("R1 trig", 2, 0);
    rd_chk("R1 en", 3, 0);
    rd_chk("R1 ctrl", 5, 0);
    rd_chk("R1 vbase", 6, 0);
  endtask

  task automatic t_select;
    wr(0, 5);  rd_chk("R2 below16", 0, 16);
    wr(0, 70); rd_chk("R2 above", 0, 16);
    wr(0, 20); rd_chk("R2 accept", 0, 20);
  endtask

  task automatic t_isolation;
    wr(0, 20); wr(1, 3);
    wr(0, 21); rd_chk("R3 neighbour prio", 1, 15);
    wr(3, 1);
    wr(0, 20); rd_chk("R3 own prio", 1, 3);
    rd_chk("R3 own en", 3, 0);
    wr(0, 21); wr(3, 0);
  endtask

  task automatic t_level;
    cfg(30, 5, 0, 1);
    @(negedge clk_i); irq_i[14] = 1'b1;
    #1 check("R11 not yet", vec_valid_o, 0);
    wait_cyc(1);
    check("R4 valid", vec_valid_o, 1);
    check("R4 vec", vec_o, 30);
    rd_chk("R4 pend rd", 4, 1);
    @(negedge clk_i); irq_i[14] = 1'b0;
    wait_cyc(1);
    check("R4 drop", vec_valid_o, 0);
    rd_chk("R4 pend clr", 4, 0);
  endtask

  task automatic t_pulse;
    cfg(40, 2, 1, 1);
    @(negedge clk_i); irq_i[24] = 1'b1;
    @(negedge clk_i); irq_i[24] = 1'b0;
    wait_cyc(2);
    check("R5 latched", vec_valid_o, 1);
    check("R5 vec", vec_o, 40);
    rd_chk("R5 pend rd", 4, 1);
    wr(4, 0); wait_cyc(2);
    check("R5 cancel0", vec_valid_o, 1);
    wr(4, 1); wait_cyc(2);
    check("R5 cancel1", vec_valid_o, 0);
    rd_chk("R5 pend clr", 4, 0);
  endtask

  task automatic t_mask;
    cfg(50, 0, 0, 0);
    @(negedge clk_i); irq_i[34] = 1'b1;
    wait_cyc(2);
    check("R6 masked", vec_valid_o, 0);
    rd_chk("R6 pend seen", 4, 1);
    wr(3, 1); wait_cyc(2);
    check("R6 unmasked", vec_o, 50);
    wr(3, 0);
    @(negedge clk_i); irq_i[34] = 1'b0;
    wait_cyc(2);
    check("R6 quiet", vec_valid_o, 0);
  endtask

  task automatic t_priority;
    cfg(45, 5, 0, 1);
    @(negedge clk_i); irq_i[14] = 1'b1; irq_i[29] = 1'b1;
    wait_cyc(2);
    check("R7 tie low vec", vec_o, 30);
    wr(0, 45); wr(1, 4); wait_cyc(2);
    check("R7 lower prio wins", vec_o, 45);
  endtask

  task automatic t_threshold;
    // line 45 prio 4 pending from previous task
    thresh_i = 5'd5; wait_cyc(2);
    check("R8 below thr", req_o, 1);
    thresh_i = 5'd4; wait_cyc(2);
    check("R8 equal thr", req_o, 0);
    check("R8 valid kept", vec_valid_o, 1);
    thresh_i = 5'd16;
    @(negedge clk_i); irq_i[14] = 1'b0; irq_i[29] = 1'b0;
    wait_cyc(2);
    check("R8 none", req_o, 0);
  endtask

  task automatic t_secure;
    wr(0, 22); wr(1, 32'h17);
    rd_chk("R9 sec+prio", 1, 32'h17);
    wr(1, 32'h06);
    rd_chk("R9 sec clr", 1, 32'h06);
  endtask

  task automatic t_save;
    wr(5, 32'hA5A5_1234); wr(6, 32'hDEAD_BE00);
    wr(9, 32'hFFFF_FFFF);
    rd_chk("R10 ctrl", 5, 32'hA5A5_1234);
    rd_chk("R10 vbase", 6, 32'hDEAD_BE00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_select();
    t_isolation();
    t_level();
    t_pulse();
    t_mask();
    t_priority();
    t_threshold();
    t_secure();
    t_save();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule